// File: doc/BRIEF.md
# 1-Wire Slot and Reset Timing Engine

This block produces the bus waveforms of a 1-Wire master: bit slots (read, write 1, write 0) and the reset pulse with presence detection, at standard or overdrive speed. A one-cycle `start` pulse selects the operation and the speed. The block then drives an active-low pull-down enable for the open-drain bus and samples the synchronised bus level at the defined point. It finishes with a one-cycle `done` pulse, a result bit and a short flag.

All durations are counted in microseconds. The microsecond tick comes from a divider of `CLK_DIV` system clocks that restarts when a command is accepted, so every duration is an exact multiple of `CLK_DIV` cycles from that edge. After the reset pulse, the engine watches for a line that is still held low by an alarm or a short. It waits a bounded time for the line to rise, then either resumes presence monitoring or finishes with the short flag set. A reset never finishes earlier than its minimum busy interval, counted from the first falling edge.

Top module: `ow_timing_engine`

## Requirements
- R1: After reset, and whenever `busy` is low, `bus_pd_n` is 1 (bus released), and `done` and `busy` are 0.
- R2: Operation codes on `op`: 2'b00 = read / write 1, 2'b01 = write 0, 2'b10 = reset. A read / write 1 pulls the bus low for exactly 1 µs. Any bit slot ends with `done` exactly 60 µs (`od`=0) or 6 µs (`od`=1) after the accepting clock edge.
- R3: A write 0 holds `bus_pd_n` low for the whole slot (60 µs or 6 µs) and reports `bit_out` = 0.
- R4: A bit slot reports in `bit_out` the synchronised bus level at 8 µs (`od`=0) or 2 µs (`od`=1) after the slot starts.
- R5: A reset holds `bus_pd_n` low for exactly 480 µs (`od`=0) or 48 µs (`od`=1), then releases it.
- R6: After the bus rises following a reset, a low level seen between 15 and 60 µs later (2 and 6 µs at overdrive) is a presence and gives `bit_out` = 0. Without one, `bit_out` = 1.
- R7: A reset signals `done` no earlier than 960 µs (`od`=0) or 96 µs (`od`=1) after the accepting edge. On a quiet or normally answered bus, `done` comes exactly then.
- R8: If the bus is still low after the reset pulse and rises within 3840 µs (384 µs at overdrive), presence monitoring continues from the rise. `done` then comes no earlier than 60 µs (6 µs) after the rise, and the presence result is valid.
- R9: If the bus does not rise within 3840 µs (384 µs) after the reset pulse, `done` comes exactly (480+3840) µs (or 48+384 µs) after start, with `short_out` = 1 and `bit_out` = 0.
- R10: A `start` pulse while `busy` is high is ignored: the running operation's timing and drive are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command pulse, accepted only when idle |
| op | input | 2 | Operation code (see R2) |
| od | input | 1 | 1 = overdrive speed for this command |
| bus_in | input | 1 | Raw bus level, synchronised inside |
| bus_pd_n | output | 1 | 0 = pull the bus low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_out | output | 1 | Sampled bit or inverted presence, held until next start |
| short_out | output | 1 | Reset ended on timeout with the bus stuck low |

## Verification
Bit slots give `done` exactly slot × `CLK_DIV` cycles after the accepting edge. Quiet and normally answered resets give it exactly 960 (or 96) × `CLK_DIV` cycles after, and stuck-low resets exactly (480+3840) (or 48+384) × `CLK_DIV` cycles after. Only the alarm release case has a window of two microseconds, because of the synchroniser and the partial first tick after the rise.

The bench counts clock edges from the accepting edge and samples `done` and `bus_pd_n` at each falling edge, so the latency and the pull-low length are measured in whole cycles and compared with these formulas. Device responses in the sample test are released three cycles before or after the sample edge. This keeps the two-cycle synchroniser delay from blurring the expected bit.

// File: rtl/ow_timing_engine.sv
module ow_timing_engine #(
  parameter int CLK_DIV = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       od,
  input  logic       bus_in,
  output logic       bus_pd_n,
  output logic       busy,
  output logic       done,
  output logic       bit_out,
  output logic       short_out
);
  localparam int SAMP_S = 8,    SAMP_O = 2;
  localparam int SLOT_S = 60,   SLOT_O = 6;
  localparam int RLOW_S = 480,  RLOW_O = 48;
  localparam int RMIN_S = 960,  RMIN_O = 96;
  localparam int ALRM_S = 3840, ALRM_O = 384;
  localparam int PLO_S  = 15,   PLO_O  = 2;
  localparam int PHI_S  = 60,   PHI_O  = 6;
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int TW = $clog2(RLOW_S + ALRM_S + PHI_S + RMIN_S);

  typedef enum logic [2:0] {S_IDLE, S_SLOT, S_RLOW, S_RREL, S_RPRES} st_t;
  st_t st;

  logic [DW-1:0] div;
  logic [TW-1:0] t, u, t_nx, u_nx;
  logic [TW-1:0] lim_samp, lim_slot, lim_rlow, lim_rmin, lim_alrm, lim_plo, lim_phi;
  logic od_q, w0_q, smp, pres, bus_m, bus_s, tick, in_win;

  assign busy = (st != S_IDLE);
  assign tick = busy && (div == DW'(CLK_DIV - 1));
  assign t_nx = t + 1'b1;
  assign u_nx = u + 1'b1;

  assign lim_samp = od_q ? TW'(SAMP_O) : TW'(SAMP_S);
  assign lim_slot = od_q ? TW'(SLOT_O) : TW'(SLOT_S);
  assign lim_rlow = od_q ? TW'(RLOW_O) : TW'(RLOW_S);
  assign lim_rmin = od_q ? TW'(RMIN_O) : TW'(RMIN_S);
  assign lim_alrm = od_q ? TW'(ALRM_O) : TW'(ALRM_S);
  assign lim_plo  = od_q ? TW'(PLO_O)  : TW'(PLO_S);
  assign lim_phi  = od_q ? TW'(PHI_O)  : TW'(PHI_S);

  assign in_win = !bus_s && (u >= lim_plo) && (u < lim_phi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      div       <= '0;
      t         <= '0;
      u         <= '0;
      od_q      <= 1'b0;
      w0_q      <= 1'b0;
      smp       <= 1'b1;
      pres      <= 1'b0;
      bus_m     <= 1'b1;
      bus_s     <= 1'b1;
      bus_pd_n  <= 1'b1;
      done      <= 1'b0;
      bit_out   <= 1'b1;
      short_out <= 1'b0;
    end else begin
      done  <= 1'b0;
      bus_m <= bus_in;
      bus_s <= bus_m;
      div   <= (!busy || tick) ? '0 : div + 1'b1;
      if (tick) begin
        t <= t_nx;
        u <= u_nx;
      end
      case (st)
        S_IDLE: if (start) begin
          od_q      <= od;
          w0_q      <= (op == 2'b01);
          t         <= '0;
          u         <= '0;
          pres      <= 1'b0;
          short_out <= 1'b0;
          bus_pd_n  <= 1'b0;
          st        <= op[1] ? S_RLOW : S_SLOT;
        end
        S_SLOT: if (tick) begin
          if (t_nx == TW'(1) && !w0_q) bus_pd_n <= 1'b1;
          if (t_nx == lim_samp) smp <= bus_s;
          if (t_nx == lim_slot) begin
            bus_pd_n <= 1'b1;
            done     <= 1'b1;
            bit_out  <= smp;
            st       <= S_IDLE;
          end
        end
        S_RLOW: if (tick && t_nx == lim_rlow) begin
          bus_pd_n <= 1'b1;
          u        <= '0;
          st       <= S_RREL;
        end
        S_RREL: begin
          if (bus_s) begin
            u  <= '0;
            st <= S_RPRES;
          end else if (tick && u_nx == lim_alrm) begin
            done      <= 1'b1;
            short_out <= 1'b1;
            bit_out   <= 1'b0;
            st        <= S_IDLE;
          end
        end
        S_RPRES: begin
          if (in_win) pres <= 1'b1;
          if (tick && t_nx >= lim_rmin && u_nx >= lim_phi) begin
            done    <= 1'b1;
            bit_out <= !(pres || in_win);
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ow_timing_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bus_pd_n,
  input logic busy,
  input logic done,
  input logic bit_out,
  input logic short_out
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_pd_n);
  // R10
  fall_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_pd_n) |-> ($past(start) && !$past(busy)));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R9
  short_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_out) |-> (done && !bit_out));
endmodule

bind ow_timing_engine ow_timing_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_pd_n(bus_pd_n),
  .busy(busy), .done(done), .bit_out(bit_out), .short_out(short_out)
);

// File: tb/ow_timing_engine_tb_top.sv
module ow_timing_engine_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, od = 1'b0, dev_low = 1'b0;
  logic [1:0] op = 2'b00;
  logic bus_pd_n, busy, done, bit_out, short_out;
  logic bus;
  assign bus = bus_pd_n & ~dev_low;

  always #10 clk = ~clk;

  ow_timing_engine #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .od(od), .bus_in(bus),
    .bus_pd_n(bus_pd_n), .busy(busy), .done(done), .bit_out(bit_out), .short_out(short_out)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  function automatic int f_slot(bit o); return o ? 6 : 60; endfunction
  function automatic int f_samp(bit o); return o ? 2 : 8; endfunction
  function automatic int f_rlow(bit o); return o ? 48 : 480; endfunction
  function automatic int f_rmin(bit o); return o ? 96 : 960; endfunction
  function automatic int f_alrm(bit o); return o ? 384 : 3840; endfunction
  function automatic int f_phi(bit o); return o ? 6 : 60; endfunction
  function automatic int imax(int a, int b); return a > b ? a : b; endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int lo, int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input bit s_od, input bit glitch,
                        output int lat, output int lowc);
    @(negedge clk);
    op = o; od = s_od; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = -1; lowc = 0;
    for (int k = 0; k < 40000; k++) begin
      if (done) begin lat = k; break; end
      if (!bus_pd_n) lowc++;
      if (glitch && k == 10) begin start = 1'b1; op = 2'b10; end
      if (glitch && k == 11) start = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    while (dev_low) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
  endtask

  task automatic dev_slot(int hold);
    fork
      begin
        @(negedge bus_pd_n);
        dev_low = 1'b1;
        repeat (hold) @(negedge clk);
        dev_low = 1'b0;
      end
    join_none
  endtask

  task automatic dev_presence(int tus);
    fork
      begin
        @(posedge bus);
        repeat (tus * DIV) @(negedge clk);
        dev_low = 1'b1;
        repeat (4 * tus * DIV) @(negedge clk);
        dev_low = 1'b0;
      end
    join_none
  endtask

  task automatic do_slot(logic [1:0] o, bit s, int pull, bit glitch);
    int lat, lowc, exp_bit;
    if (pull > 0) dev_slot(pull);
    run_op(o, s, glitch, lat, lowc);
    exp_bit = (o == 2'b01) ? 0 : ((pull > 0 && pull + 2 > f_samp(s) * DIV) ? 0 : 1);
    chk(glitch ? "R10" : "R2", "slot latency", lat, f_slot(s) * DIV);
    if (o == 2'b01) chk("R3", "write0 low cycles", lowc, f_slot(s) * DIV);
    else chk(glitch ? "R10" : "R2", "short pull cycles", lowc, DIV);
    chk(o == 2'b01 ? "R3" : "R4", "slot bit", int'(bit_out), exp_bit);
    settle();
  endtask

  task automatic do_reset(bit s, int tus);
    int lat, lowc;
    if (tus > 0) dev_presence(tus);
    run_op(2'b10, s, 1'b0, lat, lowc);
    chk("R5", "reset low cycles", lowc, f_rlow(s) * DIV);
    chk("R7", "reset latency", lat, f_rmin(s) * DIV);
    chk("R6", "presence bit", int'(bit_out), tus > 0 ? 0 : 1);
    chk("R9", "no short", int'(short_out), 0);
    settle();
  endtask

  task automatic do_alarm(bit s, int x, int tus);
    int lat, lowc, lo, hi;
    if (tus > 0) dev_presence(tus);
    fork
      begin
        repeat ((f_rlow(s) + x) * DIV + 1) @(negedge clk);
        dev_low = 1'b0;
      end
    join_none
    dev_low = 1'b1;
    run_op(2'b10, s, 1'b0, lat, lowc);
    lo = imax(f_rmin(s), f_rlow(s) + x + f_phi(s)) * DIV - DIV;
    hi = imax(f_rmin(s), f_rlow(s) + x + f_phi(s) + 2) * DIV;
    chk_rng("R8", "alarm latency", lat, lo, hi);
    chk("R8", "alarm presence bit", int'(bit_out), tus > 0 ? 0 : 1);
    chk("R8", "alarm no short", int'(short_out), 0);
    settle();
  endtask

  task automatic do_short(bit s);
    int lat, lowc;
    dev_low = 1'b1;
    run_op(2'b10, s, 1'b0, lat, lowc);
    chk("R9", "short latency", lat, (f_rlow(s) + f_alrm(s)) * DIV);
    chk("R9", "short flag", int'(short_out), 1);
    chk("R9", "short bit", int'(bit_out), 0);
    dev_low = 1'b0;
    settle();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    chk("R1", "reset drive", int'(bus_pd_n), 1);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int s = 0; s < 2; s++) begin
      do_slot(2'b00, s[0], 0, 1'b0);
      do_slot(2'b01, s[0], 0, 1'b0);
      do_slot(2'b00, s[0], f_samp(s[0]) * DIV - 3, 1'b0);
      do_slot(2'b00, s[0], f_samp(s[0]) * DIV + 3, 1'b0);
      do_reset(s[0], 0);
      do_reset(s[0], s[0] ? 3 : 30);
      do_short(s[0]);
    end
    do_slot(2'b00, 1'b0, 0, 1'b1);
    chk("R1", "idle drive", int'(bus_pd_n), 1);
    do_alarm(1'b0, 700, 20);
    do_alarm(1'b0, 200, 0);
    do_alarm(1'b1, 100, 3);

    for (int i = 0; i < 24; i++) begin
      bit s;
      int kind;
      s = 1'($urandom_range(0, 1));
      kind = $urandom_range(0, 3);
      case (kind)
        0: do_slot(2'b00, s, 0, 1'b0);
        1: do_slot(2'b01, s, 0, 1'b0);
        2: do_slot(2'b00, s, s ? $urandom_range(12, 20) : $urandom_range(36, 60), 1'b0);
        default: do_reset(s, $urandom_range(0, 1) == 1 ?
                          (s ? $urandom_range(2, 5) : $urandom_range(15, 55)) : 0);
      endcase
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule